// File: doc/BRIEF.md
# Burst-Read DMA Streamer

This block moves a buffer from memory to a consumer on its own. Software programs a base address, a byte length and a burst length through a small Wishbone register slave, then sets a start bit. The block reads the buffer over a Wishbone master port in incrementing bursts, queues the words in a local FIFO and offers them on a 32-bit valid/ready stream. A live byte counter can be read at any time. When the last word has been fetched, the busy flag drops and an interrupt is raised and held until software clears it.

The stream obeys the usual valid/ready rules. A word moves on a clock edge where both `o_valid` and `o_ready` are high. Once `o_valid` is up it stays up with `o_data` unchanged until the word is taken. Back-pressure never reaches the memory bus in the middle of a burst: a burst starts only when the FIFO has room for every beat of it, so a stalled consumer only delays the next burst.

Top module: `dma_rd_streamer`

## Requirements
- R1: After a synchronous reset, every register reads 0, `irq_o` and `o_valid` are low and no bus cycle is active.
- R2: The register slave decodes byte offsets 0x00 (control/status), 0x04 (base address), 0x08 (length in bytes) and 0x0C (burst length in words), and 0x10 (byte count, read-only). The low two bits of the base and length read back as 0.
- R3: Writing 1 to control bit 0 while idle starts a transfer, and control bit 0 reads 1 while busy. Writes to the base, length and burst registers are ignored while busy.
- R4: Beat addresses start at the base and rise by 4 per acknowledged beat. `m_stb` and `m_adr` hold until the beat is acknowledged, and `m_bte` is 2'b00.
- R5: Each burst has min(effective burst length, words remaining) beats. A burst length of 0 counts as 1 and one above the FIFO depth counts as the depth. Every beat carries `m_cti` 3'b010 except the last beat of a burst, which carries 3'b111.
- R6: The byte count clears at start, rises by 4 per acknowledged beat and never exceeds the length.
- R7: When the count reaches the length, busy clears and the interrupt (control bit 1 and `irq_o`) sets on the next edge. Starting with length 0 sets the interrupt with no bus cycle.
- R8: Writing 1 to control bit 1 clears the interrupt. Writing 0 there leaves it set.
- R9: Words leave the stream in memory order, and `o_data` is stable while `o_valid` is high and `o_ready` is low.
- R10: A burst is issued only when the FIFO has room for all its beats. With the stream stalled, fetching stops once the FIFO is full, and it resumes when the consumer drains it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_cyc | input | 1 | Register slave cycle |
| s_stb | input | 1 | Register slave strobe |
| s_we | input | 1 | Register slave write enable |
| s_adr | input | 5 | Register byte offset |
| s_dat_i | input | 32 | Register write data |
| s_ack | output | 1 | Register slave acknowledge |
| s_dat_o | output | 32 | Register read data |
| m_adr | output | 32 | Memory byte address |
| m_cyc | output | 1 | Memory bus cycle |
| m_stb | output | 1 | Memory bus strobe |
| m_cti | output | 3 | Cycle type tag |
| m_bte | output | 2 | Burst type extension |
| m_dat_i | input | 32 | Memory read data |
| m_ack | input | 1 | Memory acknowledge |
| o_data | output | 32 | Stream data |
| o_valid | output | 1 | Stream valid |
| o_ready | input | 1 | Stream ready |
| irq_o | output | 1 | Transfer-complete interrupt |

## Verification
The assertions assume a memory slave that acknowledges only while `m_cyc` and `m_stb` are high and may insert any number of wait states. They also assume software programs the block through single, non-overlapping register cycles. The bench's memory model gates its acknowledge with a pseudo-random pattern but never acknowledges outside a strobe, and its register tasks finish one access before starting the next. The bench also drops stream ready for long stretches to push the FIFO to full.

// File: rtl/dma_rd_pkg.sv
package dma_rd_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h00;
  localparam logic [REG_AW-1:0] OFS_BASE  = 5'h04;
  localparam logic [REG_AW-1:0] OFS_LEN   = 5'h08;
  localparam logic [REG_AW-1:0] OFS_BURST = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_DONE  = 5'h10;

  localparam logic [2:0] CTI_INCR = 3'b010;
  localparam logic [2:0] CTI_END  = 3'b111;
  localparam logic [1:0] BTE_LIN  = 2'b00;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BURST} fetch_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [31:0]       len;
    logic [31:0]       burst;
  } dma_cfg_t;
endpackage

// File: rtl/dma_rd_regs.sv
module dma_rd_regs
  import dma_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              s_cyc,
  input  logic              s_stb,
  input  logic              s_we,
  input  logic [REG_AW-1:0] s_adr,
  input  logic [31:0]       s_dat_i,
  output logic              s_ack,
  output logic [31:0]       s_dat_o,
  input  logic              busy,
  input  logic              irq,
  input  logic [31:0]       byte_cnt,
  output dma_cfg_t          cfg,
  output logic              start_req,
  output logic              irq_clr
);
  logic access, wr_hit;
  logic [31:0] rd_mux;

  assign access    = s_cyc && s_stb && !s_ack;
  assign wr_hit    = access && s_we;
  assign start_req = wr_hit && (s_adr == OFS_CTRL) && s_dat_i[0] && !busy;
  assign irq_clr   = wr_hit && (s_adr == OFS_CTRL) && s_dat_i[1];

  always_comb begin
    case (s_adr)
      OFS_CTRL:  rd_mux = {30'b0, irq, busy};
      OFS_BASE:  rd_mux = cfg.base;
      OFS_LEN:   rd_mux = cfg.len;
      OFS_BURST: rd_mux = cfg.burst;
      OFS_DONE:  rd_mux = byte_cnt;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ack   <= 1'b0;
      s_dat_o <= '0;
      cfg     <= '0;
    end else begin
      s_ack <= access;
      if (access) s_dat_o <= rd_mux;
      if (wr_hit && !busy) begin
        case (s_adr)
          OFS_BASE:  cfg.base  <= {s_dat_i[31:2], 2'b00};
          OFS_LEN:   cfg.len   <= {s_dat_i[31:2], 2'b00};
          OFS_BURST: cfg.burst <= s_dat_i;
          default:   ;
        endcase
      end
    end
  end

  // R3: configuration frozen while a transfer runs
  a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cfg));
endmodule

// File: rtl/dma_rd_fifo.sv
module dma_rd_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     o_data,
  output logic             o_valid,
  input  logic             o_ready,
  output logic [LVL_W-1:0] free_slots
);
  logic [W-1:0]     mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level;
  logic             pop;

  assign o_valid    = (level != '0);
  assign o_data     = mem[rd_ptr];
  assign pop        = o_valid && o_ready;
  assign free_slots = LVL_W'(DEPTH) - level;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: ;
      endcase
    end
  end

  // R10: the fetch side never writes into a full buffer
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (level < LVL_W'(DEPTH)));

  // R9: a stalled word stays put
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));
endmodule

// File: rtl/dma_rd_fetch.sv
module dma_rd_fetch
  import dma_rd_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  dma_cfg_t          cfg,
  input  logic              start_req,
  input  logic              irq_clr,
  input  logic [LVL_W-1:0]  free_slots,
  output logic [ADDR_W-1:0] m_adr,
  output logic              m_cyc,
  output logic              m_stb,
  output logic [2:0]        m_cti,
  output logic [1:0]        m_bte,
  input  logic              m_ack,
  output logic              push,
  output logic              busy,
  output logic              irq,
  output logic [31:0]       byte_cnt
);
  fetch_st_e        st;
  logic [LVL_W-1:0] beats_left;
  logic [31:0]      blen_eff, rem_words, next_len, free_ext;
  logic             last_beat;

  always_comb begin
    if (cfg.burst == '0)                blen_eff = 32'd1;
    else if (cfg.burst > 32'(DEPTH))    blen_eff = 32'(DEPTH);
    else                                blen_eff = cfg.burst;
    rem_words = (cfg.len - byte_cnt) >> 2;
    next_len  = (rem_words < blen_eff) ? rem_words : blen_eff;
    free_ext  = 32'(free_slots);
  end

  assign m_cyc     = (st == ST_BURST);
  assign m_stb     = (st == ST_BURST);
  assign last_beat = (beats_left == LVL_W'(1));
  assign m_cti     = last_beat ? CTI_END : CTI_INCR;
  assign m_bte     = BTE_LIN;
  assign push      = m_stb && m_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      beats_left <= '0;
      m_adr      <= '0;
      busy       <= 1'b0;
      irq        <= 1'b0;
      byte_cnt   <= '0;
    end else begin
      if (irq_clr) irq <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_req) begin
            byte_cnt <= '0;
            m_adr    <= cfg.base;
            if (cfg.len == '0) begin
              irq <= 1'b1;
            end else begin
              busy <= 1'b1;
              st   <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (free_ext >= next_len) begin
            beats_left <= next_len[LVL_W-1:0];
            st         <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (m_ack) begin
            m_adr      <= m_adr + 32'd4;
            byte_cnt   <= byte_cnt + 32'd4;
            beats_left <= beats_left - 1'b1;
            if (last_beat) begin
              if (byte_cnt + 32'd4 == cfg.len) begin
                busy <= 1'b0;
                irq  <= 1'b1;
                st   <= ST_IDLE;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: request held steady until acknowledged
  a_r4_stb_hold: assert property (@(posedge clk) disable iff (rst)
    (m_stb && !m_ack) |=> (m_stb && $stable(m_adr)));

  // R4: consecutive beats inside a burst step by one word
  a_r4_word_step: assert property (@(posedge clk) disable iff (rst)
    (m_stb && m_ack && (m_cti == CTI_INCR)) |=> (m_stb && (m_adr == $past(m_adr) + 32'd4)));

  // R6: count never passes the programmed length
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (byte_cnt <= cfg.len));

  // R7: interrupt only rises once the transfer has ended
  a_r7_irq_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !busy);
endmodule

// File: rtl/dma_rd_streamer.sv
module dma_rd_streamer
  import dma_rd_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_cyc,
  input  logic              s_stb,
  input  logic              s_we,
  input  logic [REG_AW-1:0] s_adr,
  input  logic [31:0]       s_dat_i,
  output logic              s_ack,
  output logic [31:0]       s_dat_o,
  output logic [ADDR_W-1:0] m_adr,
  output logic              m_cyc,
  output logic              m_stb,
  output logic [2:0]        m_cti,
  output logic [1:0]        m_bte,
  input  logic [DATA_W-1:0] m_dat_i,
  input  logic              m_ack,
  output logic [DATA_W-1:0] o_data,
  output logic              o_valid,
  input  logic              o_ready,
  output logic              irq_o
);
  localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1);

  dma_cfg_t         cfg;
  logic             start_req, irq_clr, busy, irq, push;
  logic [31:0]      byte_cnt;
  logic [LVL_W-1:0] free_slots;

  assign irq_o = irq;

  dma_rd_regs u_regs (
    .clk(clk), .rst(rst),
    .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
    .s_dat_i(s_dat_i), .s_ack(s_ack), .s_dat_o(s_dat_o),
    .busy(busy), .irq(irq), .byte_cnt(byte_cnt),
    .cfg(cfg), .start_req(start_req), .irq_clr(irq_clr)
  );

  dma_rd_fetch #(.DEPTH(FIFO_DEPTH)) u_fetch (
    .clk(clk), .rst(rst), .cfg(cfg),
    .start_req(start_req), .irq_clr(irq_clr), .free_slots(free_slots),
    .m_adr(m_adr), .m_cyc(m_cyc), .m_stb(m_stb), .m_cti(m_cti),
    .m_bte(m_bte), .m_ack(m_ack), .push(push),
    .busy(busy), .irq(irq), .byte_cnt(byte_cnt)
  );

  dma_rd_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wdata(m_dat_i),
    .o_data(o_data), .o_valid(o_valid), .o_ready(o_ready),
    .free_slots(free_slots)
  );
endmodule

// File: tb/tb_dma_rd_streamer.sv
module tb_dma_rd_streamer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_cyc = 0, s_stb = 0, s_we = 0;
  logic [4:0]  s_adr = '0;
  logic [31:0] s_dat_i = '0;
  logic        s_ack;
  logic [31:0] s_dat_o;
  logic [31:0] m_adr;
  logic        m_cyc, m_stb, m_ack;
  logic [2:0]  m_cti;
  logic [1:0]  m_bte;
  logic [31:0] m_dat_i;
  logic [31:0] o_data;
  logic        o_valid;
  logic        o_ready = 1'b1;
  logic        irq_o;

  int total = 0, bad = 0;
  int beats_seen = 0;
  logic [31:0] exp_adr;
  int rem_words = 0, eff_len = 1, bl_left = 0;
  logic [31:0] sb_q[$];
  logic [15:0] lfsr = 16'hACE1;
  logic        ack_gate = 1'b0;
  logic        held = 1'b0;
  logic [31:0] held_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_rd_streamer #(.FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst),
    .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
    .s_dat_i(s_dat_i), .s_ack(s_ack), .s_dat_o(s_dat_o),
    .m_adr(m_adr), .m_cyc(m_cyc), .m_stb(m_stb), .m_cti(m_cti),
    .m_bte(m_bte), .m_dat_i(m_dat_i), .m_ack(m_ack),
    .o_data(o_data), .o_valid(o_valid), .o_ready(o_ready), .irq_o(irq_o)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h5A00_00C3;
  endfunction

  assign m_ack   = m_cyc && m_stb && ack_gate;
  assign m_dat_i = mem_word(m_adr);

  always @(posedge clk) begin
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ack_gate <= lfsr[0] | lfsr[3];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory-side monitor: R4 addresses, R5 burst tags
  always @(negedge clk) begin
    if (!rst && m_cyc && m_stb && m_ack) begin
      beats_seen++;
      if (bl_left == 0) bl_left = (rem_words < eff_len) ? rem_words : eff_len;
      chk("R4 beat address", m_adr, exp_adr);
      chk("R4 burst type", {30'b0, m_bte}, 32'd0);
      chk("R5 cycle tag", {29'b0, m_cti}, (bl_left == 1) ? 32'd7 : 32'd2);
      exp_adr   = exp_adr + 4;
      rem_words = rem_words - 1;
      bl_left   = bl_left - 1;
    end
  end

  // stream monitor: R9 order and hold
  always @(negedge clk) begin
    if (!rst) begin
      if (held) begin
        chk("R9 valid held", {31'b0, o_valid}, 32'd1);
        chk("R9 data held", o_data, held_data);
      end
      held      = o_valid && !o_ready;
      held_data = o_data;
      if (o_valid && o_ready) begin
        if (sb_q.size() == 0) chk("R9 unexpected word", o_data, 32'hxxxx_xxxx);
        else chk("R9 stream order", o_data, sb_q.pop_front());
      end
    end
  end

  task automatic wb_wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    s_cyc = 1; s_stb = 1; s_we = 1; s_adr = a; s_dat_i = d;
    do @(negedge clk); while (!s_ack);
    @(posedge clk); #1;
    s_cyc = 0; s_stb = 0; s_we = 0;
  endtask

  task automatic wb_rd(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    s_cyc = 1; s_stb = 1; s_we = 0; s_adr = a;
    do @(negedge clk); while (!s_ack);
    d = s_dat_o;
    @(posedge clk); #1;
    s_cyc = 0; s_stb = 0;
  endtask

  task automatic launch(input logic [31:0] base, input logic [31:0] len, input logic [31:0] blen);
    exp_adr   = base;
    rem_words = len / 4;
    eff_len   = (blen == 0) ? 1 : ((blen > DEPTH) ? DEPTH : blen);
    bl_left   = 0;
    for (int i = 0; i < len / 4; i++) sb_q.push_back(mem_word(base + 4 * i));
    wb_wr(5'h04, base);
    wb_wr(5'h08, len);
    wb_wr(5'h0C, blen);
    wb_wr(5'h00, 32'd1);
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq_o && n < 5000) begin @(negedge clk); n++; end
    chk(req, {31'b0, irq_o}, 32'd1);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int b0;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_o", {31'b0, irq_o}, 0);
    chk("R1 o_valid", {31'b0, o_valid}, 0);
    chk("R1 m_cyc", {31'b0, m_cyc}, 0);
    for (int k = 0; k < 5; k++) begin
      wb_rd(5'(4 * k), r);
      chk("R1 register reset", r, 0);
    end

    // R2 register map and low-bit masking
    wb_wr(5'h04, 32'h0000_1003); wb_rd(5'h04, r); chk("R2 base readback", r, 32'h0000_1000);
    wb_wr(5'h08, 32'h0000_0042); wb_rd(5'h08, r); chk("R2 length readback", r, 32'h0000_0040);
    wb_wr(5'h0C, 32'd9);         wb_rd(5'h0C, r); chk("R2 burst readback", r, 32'd9);

    // main transfer, bursts of 4
    launch(32'h0000_1000, 64, 4);
    wait_irq("R7 completion irq");
    wb_rd(5'h10, r); chk("R6 final byte count", r, 64);
    wb_rd(5'h00, r); chk("R7 status after done", r, 32'd2);
    repeat (4) @(negedge clk);
    chk("R9 all words delivered", sb_q.size(), 0);

    // R8 interrupt clear
    wb_wr(5'h00, 32'd0); chk("R8 write 0 keeps irq", {31'b0, irq_o}, 1);
    wb_wr(5'h00, 32'd2); chk("R8 write 1 clears irq", {31'b0, irq_o}, 0);

    // R5 shortened last burst: 10 words in bursts of 4
    launch(32'h0000_3000, 40, 4);
    wait_irq("R5 short tail completes");
    wb_wr(5'h00, 32'd2);
    // R5 zero burst length means single beats
    launch(32'h0000_3400, 12, 0);
    wait_irq("R5 single beats complete");
    wb_wr(5'h00, 32'd2);
    // R5 oversized burst clamps to depth
    launch(32'h0000_3800, 128, 100);
    wait_irq("R5 clamped bursts complete");
    wb_wr(5'h00, 32'd2);
    repeat (4) @(negedge clk);
    chk("R9 words after mode runs", sb_q.size(), 0);

    // R10 back-pressure, R3 busy behaviour
    @(posedge clk); #1 o_ready = 0;
    b0 = beats_seen;
    launch(32'h0000_2000, 128, 4);
    repeat (80) @(negedge clk);
    chk("R10 beats while stalled", beats_seen - b0, DEPTH);
    chk("R10 bus idle while full", {31'b0, m_cyc}, 0);
    wb_rd(5'h10, r); chk("R6 count while stalled", r, 4 * DEPTH);
    wb_rd(5'h00, r); chk("R3 busy reads 1", r, 32'd1);
    wb_wr(5'h04, 32'h0000_5000);
    wb_rd(5'h04, r); chk("R3 base write ignored while busy", r, 32'h0000_2000);
    @(posedge clk); #1 o_ready = 1;
    wait_irq("R10 resumes and completes");
    repeat (4) @(negedge clk);
    chk("R10 all words delivered", sb_q.size(), 0);
    wb_wr(5'h00, 32'd2);

    // R7 zero length
    b0 = beats_seen;
    wb_wr(5'h08, 32'd0);
    wb_wr(5'h00, 32'd1);
    repeat (3) @(negedge clk);
    chk("R7 zero length irq", {31'b0, irq_o}, 1);
    chk("R7 zero length no beats", beats_seen - b0, 0);
    wb_rd(5'h10, r); chk("R6 zero length count", r, 0);

    finish_run();
  end
endmodule